// File: doc/BRIEF.md
# Cascaded System Tick Timer

The block turns the system clock into a set of evenly spaced time ticks. A first stage divides the clock into a microsecond tick. That tick also serves as a 1 MHz clock-enable output, so it adds no clock domain. A second stage divides microsecond ticks into millisecond ticks. A third stage divides millisecond ticks into 100 millisecond ticks. Each stage counts its input ticks from zero up to its programmed limit, then emits a one-cycle pulse, so its period is the limit plus one.

Two interval timers run on this cascade. One counts millisecond ticks and the other counts 100 millisecond ticks. Each sets a sticky status flag when its interval expires. Software can also force either flag. A flag is cleared by writing a one to its bit. The interrupt output is raised by any flag whose interrupt-enable bit is set. All limits, the enable bits and the flags are reached through an 8-bit register port, with writes taking effect at the next clock edge and reads returning data combinationally. A single enable bit starts the cascade. Clearing it stops the cascade and returns every stage counter to zero without touching the stored limits.

Register map (address: content):
- 0: control. Bit 0 is the timer enable, bit 1 the millisecond-interval interrupt enable, bit 2 the seconds-interval interrupt enable. Bits 7 to 3 read as zero.
- 1: microsecond divisor, bits 4 to 0.
- 2: millisecond divisor, low byte.
- 3: millisecond divisor, high byte.
- 4: number of millisecond ticks per 100 ms tick, minus one.
- 5: millisecond interval, in millisecond ticks minus one.
- 6: seconds interval, in 100 ms ticks minus one.
- 7: status. Bit 0 is the millisecond flag and bit 1 the seconds flag. On a write, bits 1 to 0 are write-one-to-clear and bits 3 to 2 are write-one-to-set, for the millisecond and seconds flags respectively. Bits 7 to 2 read as zero.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, control and status read 0. The divisor registers read their reset parameters: address 1 reads 0x09, address 2 reads 0xE7, address 3 reads 0x03, address 4 reads 0x63, address 5 reads 0x00 and address 6 reads 0x09. The tick and interrupt outputs are low.
- R2: Address 1 stores only bits 4 to 0. Written bits 7 to 5 have no effect, and those bits always read back as zero.
- R3: With the enable set, the microsecond tick (us_tick_o, the 1 MHz clock enable) is a one-cycle pulse every divisor+1 clock cycles. The first pulse comes in the cycle divisor cycles after the enabling edge.
- R4: The millisecond tick pulses once per ({address 3, address 2} + 1) microsecond ticks, in the same cycle as the microsecond tick that completes the count. The two bytes are stored independently.
- R5: The 100 ms tick pulses once per (address 4 + 1) millisecond ticks.
- R6: Status bit 0 becomes set in the cycle after the (address 5 + 1)-th millisecond tick since enabling.
- R7: Status bit 1 becomes set in the cycle after the (address 6 + 1)-th 100 ms tick since enabling.
- R8: A flag stays set until a one is written to its clear bit. When a hardware set and a clear fall in the same cycle, the flag stays set.
- R9: Writing a one to status bit 2 or 3 sets the millisecond or seconds flag, even while the timer is disabled.
- R10: With the enable clear, no tick pulses and no hardware flag sets occur, and all register values are kept. Re-enabling restarts every stage from zero.
- R11: irq_o is high exactly when (status bit 0 and control bit 1) or (status bit 1 and control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| us_tick_o | output | 1 | Microsecond tick, 1 MHz clock enable |
| ms_tick_o | output | 1 | Millisecond tick |
| hms_tick_o | output | 1 | 100 millisecond tick |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 5-bit microsecond divisor, an 8-bit register port and the default reset limits, which the reset readback checks. It then programs tiny limits through the register port. These put every stage's wrap, both interval expiries and the cycle where a hardware set meets a software clear within about a hundred clock cycles. With these limits, cycle-exact tick counts can be checked against periods computed in the bench.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_USDIV = 3'd1,
    A_MSLO  = 3'd2,
    A_MSHI  = 3'd3,
    A_HMS   = 3'd4,
    A_MSIV  = 3'd5,
    A_SECIV = 3'd6,
    A_STAT  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/tick_stage.sv
module tick_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  // >= guards against a limit lowered below the running count
  assign tick_o = en_i & tick_i & (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> cnt_q == '0);
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !tick_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import sys_tick_pkg::*;
#(
  parameter int DW           = 8,
  parameter int US_W         = 5,
  parameter int US_DIV_RST   = 9,
  parameter int MS_DIV_RST   = 999,
  parameter int HMS_DIV_RST  = 99,
  parameter int MS_IVAL_RST  = 0,
  parameter int SEC_IVAL_RST = 9,
  localparam int MS_W        = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            ms_hw_set_i,
  input  logic            sec_hw_set_i,
  output logic            en_o,
  output logic            ms_ie_o,
  output logic            sec_ie_o,
  output logic [US_W-1:0] us_div_o,
  output logic [MS_W-1:0] ms_div_o,
  output logic [DW-1:0]   hms_div_o,
  output logic [DW-1:0]   ms_ival_o,
  output logic [DW-1:0]   sec_ival_o,
  output logic            ms_flag_o,
  output logic            sec_flag_o
);
  logic wr_stat, ms_clr, sec_clr, ms_set, sec_set;

  assign wr_stat = we_i && (addr_i == A_STAT);
  assign ms_clr  = wr_stat && wdata_i[0];
  assign sec_clr = wr_stat && wdata_i[1];
  assign ms_set  = ms_hw_set_i  || (wr_stat && wdata_i[2]);
  assign sec_set = sec_hw_set_i || (wr_stat && wdata_i[3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      ms_ie_o    <= 1'b0;
      sec_ie_o   <= 1'b0;
      us_div_o   <= US_W'(US_DIV_RST);
      ms_div_o   <= MS_W'(MS_DIV_RST);
      hms_div_o  <= DW'(HMS_DIV_RST);
      ms_ival_o  <= DW'(MS_IVAL_RST);
      sec_ival_o <= DW'(SEC_IVAL_RST);
    end else if (we_i) begin
      case (addr_i)
        A_CTRL:  {sec_ie_o, ms_ie_o, en_o} <= wdata_i[2:0];
        A_USDIV: us_div_o            <= wdata_i[US_W-1:0];
        A_MSLO:  ms_div_o[DW-1:0]    <= wdata_i;
        A_MSHI:  ms_div_o[MS_W-1:DW] <= wdata_i;
        A_HMS:   hms_div_o           <= wdata_i;
        A_MSIV:  ms_ival_o           <= wdata_i;
        A_SECIV: sec_ival_o          <= wdata_i;
        default: ;
      endcase
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_flag_o  <= 1'b0;
      sec_flag_o <= 1'b0;
    end else begin
      ms_flag_o  <= (ms_flag_o  & ~ms_clr)  | ms_set;
      sec_flag_o <= (sec_flag_o & ~sec_clr) | sec_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[2:0]      = {sec_ie_o, ms_ie_o, en_o};
      A_USDIV: rdata_o[US_W-1:0] = us_div_o;
      A_MSLO:  rdata_o           = ms_div_o[DW-1:0];
      A_MSHI:  rdata_o           = ms_div_o[MS_W-1:DW];
      A_HMS:   rdata_o           = hms_div_o;
      A_MSIV:  rdata_o           = ms_ival_o;
      A_SECIV: rdata_o           = sec_ival_o;
      A_STAT:  rdata_o[1:0]      = {sec_flag_o, ms_flag_o};
      default: ;
    endcase
  end

  assert_us_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_USDIV) |-> rdata_o[DW-1:US_W] == '0);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_hw_set_i |=> ms_flag_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_flag_o && !(wr_stat && wdata_i[0])) |=> ms_flag_o);
  assert_sec_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_flag_o && !(wr_stat && wdata_i[1])) |=> sec_flag_o);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int DW           = 8,
  parameter int US_W         = 5,
  parameter int US_DIV_RST   = 9,
  parameter int MS_DIV_RST   = 999,
  parameter int HMS_DIV_RST  = 99,
  parameter int MS_IVAL_RST  = 0,
  parameter int SEC_IVAL_RST = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          us_tick_o,
  output logic          ms_tick_o,
  output logic          hms_tick_o,
  output logic          irq_o
);
  localparam int MS_W = 2 * DW;

  logic            en, ms_ie, sec_ie, ms_flag, sec_flag;
  logic            ms_iv_tick, sec_iv_tick;
  logic [US_W-1:0] us_div;
  logic [MS_W-1:0] ms_div;
  logic [DW-1:0]   hms_div, ms_ival, sec_ival;

  tick_regs #(
    .DW(DW), .US_W(US_W), .US_DIV_RST(US_DIV_RST), .MS_DIV_RST(MS_DIV_RST),
    .HMS_DIV_RST(HMS_DIV_RST), .MS_IVAL_RST(MS_IVAL_RST), .SEC_IVAL_RST(SEC_IVAL_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ms_hw_set_i(ms_iv_tick), .sec_hw_set_i(sec_iv_tick),
    .en_o(en), .ms_ie_o(ms_ie), .sec_ie_o(sec_ie),
    .us_div_o(us_div), .ms_div_o(ms_div), .hms_div_o(hms_div),
    .ms_ival_o(ms_ival), .sec_ival_o(sec_ival),
    .ms_flag_o(ms_flag), .sec_flag_o(sec_flag)
  );

  tick_stage #(.W(US_W)) u_us (
    .clk_i, .rst_ni, .en_i(en), .tick_i(1'b1), .lim_i(us_div), .tick_o(us_tick_o));
  tick_stage #(.W(MS_W)) u_ms (
    .clk_i, .rst_ni, .en_i(en), .tick_i(us_tick_o), .lim_i(ms_div), .tick_o(ms_tick_o));
  tick_stage #(.W(DW)) u_hms (
    .clk_i, .rst_ni, .en_i(en), .tick_i(ms_tick_o), .lim_i(hms_div), .tick_o(hms_tick_o));
  tick_stage #(.W(DW)) u_ms_iv (
    .clk_i, .rst_ni, .en_i(en), .tick_i(ms_tick_o), .lim_i(ms_ival), .tick_o(ms_iv_tick));
  tick_stage #(.W(DW)) u_sec_iv (
    .clk_i, .rst_ni, .en_i(en), .tick_i(hms_tick_o), .lim_i(sec_ival), .tick_o(sec_iv_tick));

  assign irq_o = (ms_flag & ms_ie) | (sec_flag & sec_ie);

  assert_tick_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (us_tick_o || ms_tick_o || hms_tick_o) |-> en);
  assert_cascade_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_tick_o |-> us_tick_o);
  assert_cascade_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hms_tick_o |-> ms_tick_o);
  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ms_ie && !sec_ie) |-> !irq_o);
endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       us_t, ms_t, hms_t, irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  sys_tick_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .us_tick_o(us_t), .ms_tick_o(ms_t), .hms_tick_o(hms_t), .irq_o(irq));

  // {addr, wdata, expected readback}
  localparam logic [18:0] VEC [9] = '{
    {3'd1, 8'hFF, 8'h1F}, {3'd1, 8'hE3, 8'h03}, {3'd2, 8'hA5, 8'hA5},
    {3'd3, 8'h5A, 8'h5A}, {3'd4, 8'h3C, 8'h3C}, {3'd5, 8'h81, 8'h81},
    {3'd6, 8'h7E, 8'h7E}, {3'd0, 8'h06, 8'h06}, {3'd0, 8'hF8, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic program_small();
    wr(3'd1, 8'd1); wr(3'd2, 8'd2); wr(3'd3, 8'd0);
    wr(3'd4, 8'd1); wr(3'd5, 8'd2); wr(3'd6, 8'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int us_n, ms_n, hms_n, first_us, first_ms;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 8'h00);
    rd(3'd1, d); check("R1 usdiv", d, 8'h09);
    rd(3'd2, d); check("R1 mslo", d, 8'hE7);
    rd(3'd3, d); check("R1 mshi", d, 8'h03);
    rd(3'd4, d); check("R1 hms", d, 8'h63);
    rd(3'd5, d); check("R1 msiv", d, 8'h00);
    rd(3'd6, d); check("R1 seciv", d, 8'h09);
    rd(3'd7, d); check("R1 status", d, 8'h00);
    check("R1 outputs", {us_t, ms_t, hms_t, irq}, 4'h0);

    // register vectors: R2 masking, R4 byte storage
    foreach (VEC[i]) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], d);
      check(VEC[i][18:16] == 3'd1 ? "R2 usdiv mask" : "R4 reg readback", d, VEC[i][7:0]);
    end
    rd(3'd2, d); check("R4 low byte kept", d, 8'hA5);

    // R3/R4/R5 tick periods, R6/R7 flag timing
    program_small();
    wr(3'd0, 8'h01);
    us_n = 0; ms_n = 0; hms_n = 0;
    for (int c = 0; c < 120; c++) begin
      us_n += us_t; ms_n += ms_t; hms_n += hms_t;
      if (c == 1)  check("R3 first us tick", us_t, 1'b1);
      if (c == 5)  check("R4 first ms tick", ms_t, 1'b1);
      if (c == 11) check("R5 first 100ms tick", hms_t, 1'b1);
      if (c == 17) begin rd(3'd7, d); check("R6 ms flag before", d[0], 1'b0); end
      if (c == 18) begin rd(3'd7, d); check("R6 ms flag set", d[0], 1'b1); end
      if (c == 23) begin rd(3'd7, d); check("R7 sec flag before", d[1], 1'b0); end
      if (c == 24) begin rd(3'd7, d); check("R7 sec flag set", d[1], 1'b1); end
      @(negedge clk);
    end
    check("R3 us tick count", us_n, 60);
    check("R4 ms tick count", ms_n, 20);
    check("R5 100ms tick count", hms_n, 10);
    check("R11 irq masked", irq, 1'b0);

    // R8 set wins over same-cycle clear, then plain clear
    wr(3'd0, 8'h00);
    wr(3'd7, 8'h03);
    rd(3'd7, d); check("R8 clear both", d, 8'h00);
    wr(3'd0, 8'h01);
    repeat (16) @(negedge clk);
    wr(3'd7, 8'h01);
    rd(3'd7, d); check("R8 set wins", d[0], 1'b1);
    wr(3'd7, 8'h01);
    rd(3'd7, d); check("R8 w1c clear", d[0], 1'b0);

    // R10 disable: no ticks, regs kept, restart from zero
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h00);
    wr(3'd7, 8'h03);
    us_n = 0;
    for (int c = 0; c < 40; c++) begin
      us_n += us_t + ms_t + hms_t;
      @(negedge clk);
    end
    check("R10 no ticks when off", us_n, 0);
    rd(3'd7, d); check("R10 no hw flag when off", d, 8'h00);
    rd(3'd1, d); check("R10 usdiv kept", d, 8'h01);
    rd(3'd6, d); check("R10 seciv kept", d, 8'h01);
    wr(3'd0, 8'h01);
    first_us = -1; first_ms = -1;
    for (int c = 0; c < 8; c++) begin
      if (us_t && first_us < 0) first_us = c;
      if (ms_t && first_ms < 0) first_ms = c;
      @(negedge clk);
    end
    check("R10 us restart", first_us, 1);
    check("R10 ms restart", first_ms, 5);

    // R9 software force, R11 interrupt gating
    wr(3'd0, 8'h00);
    wr(3'd7, 8'h03);
    wr(3'd7, 8'h04);
    rd(3'd7, d); check("R9 force ms", d, 8'h01);
    wr(3'd0, 8'h04);
    check("R11 ms flag sec ie", irq, 1'b0);
    wr(3'd0, 8'h02);
    check("R11 ms flag ms ie", irq, 1'b1);
    wr(3'd7, 8'h09);
    rd(3'd7, d); check("R9 force sec", d, 8'h02);
    check("R11 sec flag ms ie", irq, 1'b0);
    wr(3'd0, 8'h04);
    check("R11 sec flag sec ie", irq, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule